// File: doc/BRIEF.md
# Three-Wire Serial Slave Port

This block is the device side of a synchronous three-wire link. The link has a select line that frames each transfer, a serial clock driven by the host, and one data line that carries bits in both directions. The block oversamples the select, clock and data inputs with a fast system clock and finds the clock edges in that domain. Each transfer opens with a command byte. The command chooses read or write, the target space (timekeeping registers or scratch RAM) and a register address. One data byte then moves in or out, or a run of bytes in burst mode.

On the back-end side the block issues single-cycle read and write requests. Each request carries a space bit, an address and, for writes, a data byte. Read data must come back on the next system clock. The data line leaves the block as a value plus an output enable, so a pad or a tristate wrapper can merge the two.

Top module: `tws_slave`

## Requirements
- R1: After reset `sdio_oe_o`, `rd_req_o` and `wr_req_o` are low. Whenever `sel_i` is low, `sdio_oe_o` is low in the same instant, without waiting for a system clock edge. Lowering `sel_i` ends any transfer.
- R2: The first eight serial clock rising edges after `sel_i` rises sample a command byte, least significant bit first. Bit 0 selects the direction (1 read, 0 write). Bits 5..1 hold the address. Bit 6 selects the space (0 timekeeping registers, 1 RAM). Bit 7 enables writes.
- R3: In a write, the next eight rising edges sample a data byte, least significant bit first. The block then raises `wr_req_o` for one system clock, together with the space, the address and the byte.
- R4: A write command with bit 7 at 0 issues no write request for the rest of the transfer.
- R5: After a single-byte write, further serial clock cycles issue no request.
- R6: A read command raises `rd_req_o` after its eighth bit. Bit 0 of the returned byte is driven after the first falling edge that follows the command, and each later bit after the next falling edge, least significant bit first.
- R7: `sdio_oe_o` goes low within four system clocks of each serial clock rising edge. It is high only during the data phase of a read.
- R8: In a single-byte read, extra serial clock cycles resend the byte. A new read request to the same address is issued for each repeat.
- R9: Address 31 selects burst mode. Bursts start at address 0 and the address increments after each byte. A burst read wraps to 0 after register 7 in the timekeeping space and after word 30 in RAM. Address 31 is never requested.
- R10: A burst write stops after the last location of its space (8 registers or 31 words). Later bytes issue no request.
- R11: `rd_req_o` and `wr_req_o` are never high in the same cycle, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Transfer select, high during a transfer |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data arriving from the host |
| sdio_o | output | 1 | Serial data sent toward the host |
| sdio_oe_o | output | 1 | Output enable for the data line |
| rd_req_o | output | 1 | Read request pulse |
| rd_space_o | output | 1 | Read space, 1 for RAM |
| rd_addr_o | output | 5 | Read address |
| rd_data_i | input | 8 | Read data, valid one clock after the request |
| wr_req_o | output | 1 | Write request pulse |
| wr_space_o | output | 1 | Write space, 1 for RAM |
| wr_addr_o | output | 5 | Write address |
| wr_data_o | output | 8 | Write data |

## Verification
Single-byte writes followed by read-back cover both spaces at the low and high address ends, so a swapped space bit or a misread address field reads back the wrong byte. A write with bit 7 clear and a write followed by stray clock cycles separate a correct write gate from one that counts only bits. Burst runs with extra bytes in each space test the increment, the wrap points that differ between the two spaces, and the stop at the end of a write burst. Probes of the enable just after a rising edge, and just after select drops in mid-byte, test the two release paths of the data line.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_HOLD
  } tws_state_e;

  // command layout on the wire, bit 0 arrives first
  typedef struct packed {
    logic              wr_en;
    logic              ram;
    logic [ADDR_W-1:0] addr;
    logic              rd;
  } tws_cmd_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int unsigned CLK_REGS  = 8,
  parameter int unsigned RAM_WORDS = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_s_i,
  input  logic              sclk_s_i,
  input  logic              din_s_i,
  output tws_state_e        state_o,
  output logic              rise_o,
  output logic              fall_o,
  output logic              rd_req_o,
  output logic              rd_space_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_req_o,
  output logic              wr_space_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [ADDR_W-1:0] CLK_LAST = ADDR_W'(CLK_REGS - 1);
  localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_WORDS - 1);

  tws_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, shifted;
  logic [ADDR_W-1:0] addr_q, addr_n, last_addr;
  logic              space_q, space_n;
  logic              burst_q, burst_n;
  logic              rd_req_q, rd_req_n;
  logic              wr_req_q, wr_req_n;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_n;
  logic [BYTE_W-1:0] wr_data_q, wr_data_n;
  logic              sclk_q;
  logic              rise, fall;
  tws_cmd_t          cmd;

  assign rise      = sclk_s_i & ~sclk_q;
  assign fall      = ~sclk_s_i & sclk_q;
  assign shifted   = {din_s_i, sh_q[BYTE_W-1:1]};
  assign cmd       = tws_cmd_t'(shifted);
  assign last_addr = space_q ? RAM_LAST : CLK_LAST;

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    addr_n    = addr_q;
    space_n   = space_q;
    burst_n   = burst_q;
    rd_req_n  = 1'b0;
    wr_req_n  = 1'b0;
    wr_addr_n = wr_addr_q;
    wr_data_n = wr_data_q;
    if (!sel_s_i) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_n = ST_CMD;
          cnt_n   = '0;
        end
        ST_CMD: begin
          if (rise) begin
            sh_n  = shifted;
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              space_n = cmd.ram;
              burst_n = &cmd.addr;
              addr_n  = (&cmd.addr) ? '0 : cmd.addr;
              if (cmd.rd) begin
                state_n  = ST_RD;
                rd_req_n = 1'b1;
              end else if (cmd.wr_en) begin
                state_n = ST_WR;
              end else begin
                state_n = ST_HOLD;
              end
            end
          end
        end
        ST_WR: begin
          if (rise) begin
            sh_n  = shifted;
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              wr_req_n  = 1'b1;
              wr_addr_n = addr_q;
              wr_data_n = shifted;
              if (burst_q && (addr_q != last_addr)) addr_n = addr_q + 1'b1;
              else                                  state_n = ST_HOLD;
            end
          end
        end
        ST_RD: begin
          if (fall) begin
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              rd_req_n = 1'b1;
              if (burst_q) addr_n = (addr_q == last_addr) ? '0 : addr_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      addr_q    <= '0;
      space_q   <= 1'b0;
      burst_q   <= 1'b0;
      rd_req_q  <= 1'b0;
      wr_req_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      sclk_q    <= 1'b0;
    end else begin
      state_q   <= state_n;
      cnt_q     <= cnt_n;
      sh_q      <= sh_n;
      addr_q    <= addr_n;
      space_q   <= space_n;
      burst_q   <= burst_n;
      rd_req_q  <= rd_req_n;
      wr_req_q  <= wr_req_n;
      wr_addr_q <= wr_addr_n;
      wr_data_q <= wr_data_n;
      sclk_q    <= sclk_s_i;
    end
  end

  assign state_o    = state_q;
  assign rise_o     = rise;
  assign fall_o     = fall;
  assign rd_req_o   = rd_req_q;
  assign rd_space_o = space_q;
  assign rd_addr_o  = addr_q;
  assign wr_req_o   = wr_req_q;
  assign wr_space_o = space_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
endmodule

// File: rtl/tws_tx.sv
module tws_tx
  import tws_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_req_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic              active_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              sel_raw_i,
  output logic              sdio_o,
  output logic              sdio_oe_o
);
  logic              load_q;
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic              dout_q, dout_n;
  logic              oe_q, oe_n;

  always_comb begin
    tx_n   = tx_q;
    dout_n = dout_q;
    oe_n   = oe_q;
    if (!active_i) begin
      oe_n = 1'b0;
    end else if (fall_i) begin
      dout_n = tx_q[0];
      tx_n   = {1'b0, tx_q[BYTE_W-1:1]};
      oe_n   = 1'b1;
    end else if (rise_i) begin
      oe_n = 1'b0;
    end
    if (load_q) tx_n = rd_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      tx_q   <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      load_q <= load_req_i;
      tx_q   <= tx_n;
      dout_q <= dout_n;
      oe_q   <= oe_n;
    end
  end

  assign sdio_o    = dout_q;
  assign sdio_oe_o = oe_q & sel_raw_i;
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int unsigned CLK_REGS    = 8,
  parameter int unsigned RAM_WORDS   = 31,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        sclk_i,
  input  logic        sdio_i,
  output logic        sdio_o,
  output logic        sdio_oe_o,
  output logic        rd_req_o,
  output logic        rd_space_o,
  output logic [4:0]  rd_addr_o,
  input  logic [7:0]  rd_data_i,
  output logic        wr_req_o,
  output logic        wr_space_o,
  output logic [4:0]  wr_addr_o,
  output logic [7:0]  wr_data_o
);
  localparam int unsigned PIN_W = 3;

  logic [PIN_W-1:0] pins_s;
  tws_state_e       state_w;
  logic             rise_w, fall_w;

  tws_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sel_i, sclk_i, sdio_i}),
    .q_o    (pins_s)
  );

  tws_ctrl #(.CLK_REGS(CLK_REGS), .RAM_WORDS(RAM_WORDS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_s_i    (pins_s[2]),
    .sclk_s_i   (pins_s[1]),
    .din_s_i    (pins_s[0]),
    .state_o    (state_w),
    .rise_o     (rise_w),
    .fall_o     (fall_w),
    .rd_req_o   (rd_req_o),
    .rd_space_o (rd_space_o),
    .rd_addr_o  (rd_addr_o),
    .wr_req_o   (wr_req_o),
    .wr_space_o (wr_space_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  tws_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_req_i (rd_req_o),
    .rd_data_i  (rd_data_i),
    .active_i   (state_w == ST_RD),
    .fall_i     (fall_w),
    .rise_i     (rise_w),
    .sel_raw_i  (sel_i),
    .sdio_o     (sdio_o),
    .sdio_oe_o  (sdio_oe_o)
  );
endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk
  import tws_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       sdio_oe_o,
  input logic       rd_req_o,
  input logic [4:0] rd_addr_o,
  input logic       wr_req_o,
  input tws_state_e state_i
);
  p_oe_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> !sdio_oe_o);

  p_wr_from_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> $past(state_i) == ST_WR);

  p_oe_read_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> state_i == ST_RD);

  p_no_addr31_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o != 5'd31);

  p_req_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));

  p_wr_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> !wr_req_o);

  p_rd_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
endmodule

bind tws_slave tws_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .sdio_oe_o (sdio_oe_o),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .wr_req_o  (wr_req_o),
  .state_i   (state_w)
);

// File: tb/tws_slave_bench.sv
module tws_slave_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF       = 8;
  localparam int  NVEC       = 8;
  // {command, write data, expected read byte or expected write count}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h84_5A_01, 24'h85_00_5A, 24'hCA_C3_01, 24'hCB_00_C3,
    24'hFC_7E_01, 24'hFD_00_7E, 24'h4A_11_00, 24'hCB_00_C3
  };

  logic       clk, rst_n, sel, sclk, sdi;
  logic       sdio_o, sdio_oe, rd_req, rd_space, wr_req, wr_space;
  logic [4:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [7:0] clk_mem [32];
  logic [7:0] ram_mem [32];
  int         wr_cnt, rd_cnt, checks, errors;

  tws_slave u_tws_slave (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .sclk_i(sclk), .sdio_i(sdi),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .rd_req_o(rd_req),
    .rd_space_o(rd_space), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_req_o(wr_req), .wr_space_o(wr_space), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // back-end model: registered read data, one clock after the request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        clk_mem[i] <= 8'h00;
        ram_mem[i] <= 8'h00;
      end
      rd_data <= 8'h00;
      wr_cnt  <= 0;
      rd_cnt  <= 0;
    end else begin
      if (wr_req) begin
        if (wr_space) ram_mem[wr_addr] <= wr_data;
        else          clk_mem[wr_addr] <= wr_data;
        wr_cnt <= wr_cnt + 1;
      end
      if (rd_req) begin
        rd_data <= rd_space ? ram_mem[rd_addr] : clk_mem[rd_addr];
        rd_cnt  <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_xfer();
    sclk = 1'b0;
    sel  = 1'b1;
    wait_cyc(4);
  endtask

  task automatic end_xfer();
    sclk = 1'b0;
    sel  = 1'b0;
    wait_cyc(6);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sdi = b[i];
      wait_cyc(HALF);
      sclk = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      wait_cyc(HALF);
      b[i] = sdio_oe ? sdio_o : 1'bx;
      sclk = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int         w0, r0;
    checks = 0; errors = 0;
    rst_n = 1'b0; sel = 1'b0; sclk = 1'b0; sdi = 1'b0;
    wait_cyc(3);
    chk("R1 oe in reset", {31'd0, sdio_oe}, 0);
    chk("R1 requests in reset", {30'd0, rd_req, wr_req}, 0);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R1 oe after reset", {31'd0, sdio_oe}, 0);

    // table walk: R2 R3 R4 R6 single-byte traffic in both spaces
    for (int v = 0; v < NVEC; v++) begin
      w0 = wr_cnt;
      begin_xfer();
      send_byte(VEC[v][23:16]);
      if (VEC[v][16]) begin
        recv_byte(b);
        chk($sformatf("R2 R6 read cmd %0h", VEC[v][23:16]), b, VEC[v][7:0]);
      end else begin
        send_byte(VEC[v][15:8]);
        wait_cyc(4);
        chk($sformatf("R3 R4 write count cmd %0h", VEC[v][23:16]), wr_cnt - w0, VEC[v][7:0]);
      end
      end_xfer();
    end

    // R5: single write followed by stray cycles
    w0 = wr_cnt;
    begin_xfer(); send_byte(8'hCE); send_byte(8'h3C); send_byte(8'hFF); end_xfer();
    chk("R5 one request only", wr_cnt - w0, 1);
    // R8: single read repeats the same byte
    r0 = rd_cnt;
    begin_xfer(); send_byte(8'hCF);
    recv_byte(b); chk("R8 first byte", b, 8'h3C);
    recv_byte(b); chk("R8 repeated byte", b, 8'h3C);
    end_xfer();
    chk("R8 read request per byte", rd_cnt - r0, 3);

    // R7: enable released shortly after a rising edge
    begin_xfer(); send_byte(8'h85);
    wait_cyc(HALF);
    chk("R6 R7 driven before rise", {31'd0, sdio_oe}, 1);
    sclk = 1'b1;
    wait_cyc(5);
    chk("R7 released after rise", {31'd0, sdio_oe}, 0);
    wait_cyc(HALF - 5);
    sclk = 1'b0;
    end_xfer();

    // R1: select drops in mid-byte
    begin_xfer(); send_byte(8'hCB);
    wait_cyc(HALF);
    sel = 1'b0;
    #1;
    chk("R1 oe drops with select", {31'd0, sdio_oe}, 0);
    wait_cyc(6);
    chk("R1 stays released", {31'd0, sdio_oe}, 0);

    // R9: RAM burst write then read
    begin_xfer(); send_byte(8'hFE);
    send_byte(8'hA0); send_byte(8'hA1); send_byte(8'hA2); end_xfer();
    begin_xfer(); send_byte(8'hFF);
    for (int k = 0; k < 3; k++) begin
      recv_byte(b);
      chk($sformatf("R9 ram burst byte %0d", k), b, 8'hA0 + k[7:0]);
    end
    end_xfer();

    // R10: clock burst write with a ninth byte
    w0 = wr_cnt;
    begin_xfer(); send_byte(8'hBE);
    for (int k = 0; k < 9; k++) send_byte((k == 8) ? 8'h99 : 8'h10 + k[7:0]);
    end_xfer();
    chk("R10 clock burst writes", wr_cnt - w0, 8);
    begin_xfer(); send_byte(8'h91); recv_byte(b); end_xfer();
    chk("R10 register 8 untouched", b, 8'h00);

    // R9: clock burst read wraps after register 7
    begin_xfer(); send_byte(8'hBF);
    for (int k = 0; k < 9; k++) begin
      recv_byte(b);
      if (k == 3 || k == 7 || k == 8)
        chk($sformatf("R9 clock burst byte %0d", k), b, (k == 8) ? 8'h10 : 8'h10 + k[7:0]);
    end
    end_xfer();

    // R9: RAM burst read wraps after word 30
    begin_xfer(); send_byte(8'hFF);
    for (int k = 0; k < 32; k++) begin
      recv_byte(b);
      if (k == 30) chk("R9 ram word 30", b, 8'h7E);
      if (k == 31) chk("R9 ram wrap to 0", b, 8'hA0);
    end
    end_xfer();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule